// File: doc/BRIEF.md
# Register File Token Shadow

This block is the one-bit control shadow of a single register file inside a coarse-grained reconfigurable array. It does not hold any data. Instead it watches and creates the tokens that tell array resources when data is about to arrive. A token is a single bit announcing that a value will land on a consumer's input in the following cycle. Each token carries a staging-predicate bit beside it.

Each write port of the register file has a receiver. The receiver looks at the token lines from every producer that can reach that port. From the position of the token that is present, it derives the write-mux select and the write enable for the next cycle. A token that enters the file this way goes no further. Each read port has a sender, and the senders are the only place where new tokens begin. On every cycle a sender reads one entry from its own small configuration memory, addressed by the kernel slot index. The entry holds a generation bit and two destination slots. When the generation bit is set, the sender drives a token to each consumer that a valid slot names. Each token carries the port's staging predicate.

Top module: `rf_token_shadow`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is 0. Reset also clears every configuration entry, so a read of any slot before loading produces no tokens.
- R2: Suppose write port w sees exactly one asserted line i in `wr_tok_vld_i[w*NUM_SRC +: NUM_SRC]` in cycle t, and that line's predicate bit is 1. Then in cycle t+1 `wr_en_o[w]` is 1 and `wr_sel_o[w*SELW +: SELW]` equals i.
- R3: When the single asserted token carries predicate 0, the write is suppressed in cycle t+1: the enable is 0, the select is 0 and the error flag is 0.
- R4: When no token line of a port is asserted, that port's enable, select and error flag are 0 in the next cycle.
- R5: When two or more token lines of one port are asserted in the same cycle, `wr_err_o[w]` is 1 in the next cycle, and the enable and select are 0.
- R6: Predicate bits on token lines whose valid bit is 0 have no effect on any output.
- R7: A configuration write stores the generation bit and both destination slots for the read port `cfg_port_i` at entry `cfg_addr_i`. It leaves every other port and entry unchanged.
- R8: When `slot_i` is a in cycle t and entry a of read port r has its generation bit set, then in cycle t+1 `rd_tok_vld_o[r*NUM_DST + d]` is 1 exactly for the consumers d named by a valid slot. `rd_tok_prd_o` carries the value of `stage_i[r]` from cycle t on those same lines.
- R9: When the generation bit of the entry read is 0, that port drives no token and no predicate.
- R10: A destination slot is valid only when exactly one of its NUM_DST bits is set. A slot that is all zero, or has more than one bit set, names no consumer.
- R11: If both slots name the same consumer, a single token goes to that consumer, so each port raises at most two token lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_tok_vld_i | input | NUM_WR*NUM_SRC | Incoming token valid lines, NUM_SRC per write port |
| wr_tok_prd_i | input | NUM_WR*NUM_SRC | Staging-predicate bit beside each incoming token |
| wr_en_o | output | NUM_WR | Register write enable for the next cycle, one per write port |
| wr_sel_o | output | NUM_WR*SELW | Write-mux select for each write port |
| wr_err_o | output | NUM_WR | More than one token arrived at the port |
| cfg_we_i | input | 1 | Configuration entry write strobe |
| cfg_port_i | input | PW | Read port whose memory is written |
| cfg_addr_i | input | AW | Entry written |
| cfg_gen_i | input | 1 | Generation bit to store |
| cfg_dst0_i | input | NUM_DST | First destination slot, one-hot or zero |
| cfg_dst1_i | input | NUM_DST | Second destination slot, one-hot or zero |
| slot_i | input | AW | Kernel slot index used to read every port's memory |
| stage_i | input | NUM_RD | Staging predicate for each read port |
| rd_tok_vld_o | output | NUM_RD*NUM_DST | Outgoing tokens, NUM_DST consumers per read port |
| rd_tok_prd_o | output | NUM_RD*NUM_DST | Predicate bit beside each outgoing token |

## Verification
The receivers are driven through every valid-line pattern crossed with every predicate pattern on one port. At the same time the other port receives the complemented lines. This covers single-token writes and suppressed writes, and separates them from idle and conflicting cycles, including predicates left on idle lines. The senders are loaded and read back across both values of the generation bit and every pair of four-bit destination slots. That sweep separates one-hot slots from zero and multi-bit slots, and catches duplicate destinations. The staging predicate changes along the sweep, which shows that it follows only the lines that carry tokens. A read of every entry straight after reset shows that the configuration memories start cleared.

// File: rtl/rft_pkg.sv
package rft_pkg;

    localparam int RFT_NUM_WR    = 2;
    localparam int RFT_NUM_SRC   = 4;
    localparam int RFT_NUM_RD    = 2;
    localparam int RFT_NUM_DST   = 4;
    localparam int RFT_CFG_DEPTH = 8;

    typedef enum logic [1:0] {
        RX_IDLE     = 2'd0,
        RX_WRITE    = 2'd1,
        RX_SQUASH   = 2'd2,
        RX_CONFLICT = 2'd3
    } rx_kind_e;

    typedef struct packed {
        logic     en;
        logic     err;
        rx_kind_e kind;
    } rx_flags_t;

    function automatic rx_kind_e rx_classify(input int hits, input logic pred);
        if (hits == 0)
            return RX_IDLE;
        else if (hits > 1)
            return RX_CONFLICT;
        else if (pred)
            return RX_WRITE;
        else
            return RX_SQUASH;
    endfunction

    function automatic rx_flags_t rx_flags(input rx_kind_e kind);
        rx_flags_t f;
        f.kind = kind;
        f.en   = (kind == RX_WRITE);
        f.err  = (kind == RX_CONFLICT);
        return f;
    endfunction

endpackage

// File: rtl/rft_wr_receiver.sv
module rft_wr_receiver
    import rft_pkg::*;
#(
    parameter  int NUM_SRC = RFT_NUM_SRC,
    localparam int SELW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] tok_vld_i,
    input  logic [NUM_SRC-1:0] tok_prd_i,
    output logic               wr_en_o,
    output logic [SELW-1:0]    wr_sel_o,
    output logic               wr_err_o
);

    logic [SELW-1:0] hit_idx;
    logic            hit_prd;
    rx_flags_t       flags;

    // Lowest asserted line wins the index search; conflicts are flagged below.
    always_comb begin
        hit_idx = '0;
        hit_prd = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (tok_vld_i[i]) begin
                hit_idx = SELW'(i);
                hit_prd = tok_prd_i[i];
            end
        end
        flags = rx_flags(rx_classify($countones(tok_vld_i), hit_prd));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_en_o  <= 1'b0;
            wr_sel_o <= '0;
            wr_err_o <= 1'b0;
        end else begin
            wr_en_o  <= flags.en;
            wr_sel_o <= flags.en ? hit_idx : '0;
            wr_err_o <= flags.err;
        end
    end

endmodule

// File: rtl/rft_cfg_mem.sv
module rft_cfg_mem #(
    parameter  int DEPTH = 8,
    parameter  int ENTW  = 9,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [ENTW-1:0] wdata_i,
    input  logic [AW-1:0]   raddr_i,
    output logic [ENTW-1:0] rdata_o
);

    logic [ENTW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int e = 0; e < DEPTH; e++)
                mem_q[e] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Registered read: the entry for a slot appears one cycle later.
    always_ff @(posedge clk_i) begin
        if (rst_i)
            rdata_o <= '0;
        else
            rdata_o <= mem_q[raddr_i];
    end

endmodule

// File: rtl/rft_rd_sender.sv
module rft_rd_sender #(
    parameter  int NUM_DST = 4,
    localparam int ENTW    = 1 + 2 * NUM_DST
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [ENTW-1:0]    entry_i,
    input  logic               stage_i,
    output logic [NUM_DST-1:0] tok_vld_o,
    output logic [NUM_DST-1:0] tok_prd_o
);

    typedef struct packed {
        logic [NUM_DST-1:0] dst1;
        logic [NUM_DST-1:0] dst0;
        logic               gen;
    } entry_t;

    entry_t             ent;
    logic               stage_q;
    logic [NUM_DST-1:0] reach0;
    logic [NUM_DST-1:0] reach1;

    // Predicate is sampled alongside the memory read so both align.
    always_ff @(posedge clk_i) begin
        if (rst_i)
            stage_q <= 1'b0;
        else
            stage_q <= stage_i;
    end

    always_comb begin
        ent       = entry_t'(entry_i);
        reach0    = ($countones(ent.dst0) == 1) ? ent.dst0 : '0;
        reach1    = ($countones(ent.dst1) == 1) ? ent.dst1 : '0;
        tok_vld_o = ent.gen ? (reach0 | reach1) : '0;
        tok_prd_o = stage_q ? tok_vld_o : '0;
    end

endmodule

// File: rtl/rf_token_shadow.sv
module rf_token_shadow
    import rft_pkg::*;
#(
    parameter  int NUM_WR    = RFT_NUM_WR,
    parameter  int NUM_SRC   = RFT_NUM_SRC,
    parameter  int NUM_RD    = RFT_NUM_RD,
    parameter  int NUM_DST   = RFT_NUM_DST,
    parameter  int CFG_DEPTH = RFT_CFG_DEPTH,
    localparam int SELW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int AW        = (CFG_DEPTH > 1) ? $clog2(CFG_DEPTH) : 1,
    localparam int PW        = (NUM_RD > 1) ? $clog2(NUM_RD) : 1
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [NUM_WR*NUM_SRC-1:0] wr_tok_vld_i,
    input  logic [NUM_WR*NUM_SRC-1:0] wr_tok_prd_i,
    output logic [NUM_WR-1:0]         wr_en_o,
    output logic [NUM_WR*SELW-1:0]    wr_sel_o,
    output logic [NUM_WR-1:0]         wr_err_o,
    input  logic                      cfg_we_i,
    input  logic [PW-1:0]             cfg_port_i,
    input  logic [AW-1:0]             cfg_addr_i,
    input  logic                      cfg_gen_i,
    input  logic [NUM_DST-1:0]        cfg_dst0_i,
    input  logic [NUM_DST-1:0]        cfg_dst1_i,
    input  logic [AW-1:0]             slot_i,
    input  logic [NUM_RD-1:0]         stage_i,
    output logic [NUM_RD*NUM_DST-1:0] rd_tok_vld_o,
    output logic [NUM_RD*NUM_DST-1:0] rd_tok_prd_o
);

    localparam int ENTW = 1 + 2 * NUM_DST;

    logic [ENTW-1:0] cfg_word;
    assign cfg_word = {cfg_dst1_i, cfg_dst0_i, cfg_gen_i};

    for (genvar w = 0; w < NUM_WR; w++) begin : g_rx
        rft_wr_receiver #(.NUM_SRC(NUM_SRC)) rx_i (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .tok_vld_i (wr_tok_vld_i[w*NUM_SRC +: NUM_SRC]),
            .tok_prd_i (wr_tok_prd_i[w*NUM_SRC +: NUM_SRC]),
            .wr_en_o   (wr_en_o[w]),
            .wr_sel_o  (wr_sel_o[w*SELW +: SELW]),
            .wr_err_o  (wr_err_o[w])
        );
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_tx
        logic            port_we;
        logic [ENTW-1:0] entry;

        assign port_we = cfg_we_i && (cfg_port_i == PW'(r));

        rft_cfg_mem #(.DEPTH(CFG_DEPTH), .ENTW(ENTW)) mem_i (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .we_i    (port_we),
            .waddr_i (cfg_addr_i),
            .wdata_i (cfg_word),
            .raddr_i (slot_i),
            .rdata_o (entry)
        );

        rft_rd_sender #(.NUM_DST(NUM_DST)) tx_i (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .entry_i   (entry),
            .stage_i   (stage_i[r]),
            .tok_vld_o (rd_tok_vld_o[r*NUM_DST +: NUM_DST]),
            .tok_prd_o (rd_tok_prd_o[r*NUM_DST +: NUM_DST])
        );
    end

endmodule

// File: rtl/rf_token_shadow_chk.sv
module rf_token_shadow_chk #(
    parameter  int NUM_WR  = 2,
    parameter  int NUM_SRC = 4,
    parameter  int NUM_RD  = 2,
    parameter  int NUM_DST = 4,
    localparam int SELW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic                      clk_i,
    input logic                      rst_i,
    input logic [NUM_WR*NUM_SRC-1:0] wr_tok_vld_i,
    input logic [NUM_WR*NUM_SRC-1:0] wr_tok_prd_i,
    input logic [NUM_WR-1:0]         wr_en_o,
    input logic [NUM_WR*SELW-1:0]    wr_sel_o,
    input logic [NUM_WR-1:0]         wr_err_o,
    input logic [NUM_RD*NUM_DST-1:0] rd_tok_vld_o,
    input logic [NUM_RD*NUM_DST-1:0] rd_tok_prd_o
);

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        $past(rst_i) |-> (wr_en_o == '0 && wr_err_o == '0 && rd_tok_vld_o == '0));

    for (genvar w = 0; w < NUM_WR; w++) begin : g_w
        assert_single_write_R2: assert property (@(posedge clk_i) disable iff (rst_i)
            ($countones(wr_tok_vld_i[w*NUM_SRC +: NUM_SRC]) == 1 &&
             (wr_tok_vld_i[w*NUM_SRC +: NUM_SRC] & wr_tok_prd_i[w*NUM_SRC +: NUM_SRC]) != '0)
            |=> wr_en_o[w]);

        assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            (wr_tok_vld_i[w*NUM_SRC +: NUM_SRC] == '0)
            |=> (!wr_en_o[w] && !wr_err_o[w] && wr_sel_o[w*SELW +: SELW] == '0));

        assert_conflict_flag_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            ($countones(wr_tok_vld_i[w*NUM_SRC +: NUM_SRC]) > 1) |=> wr_err_o[w]);

        assert_conflict_no_write_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            wr_err_o[w] |-> !wr_en_o[w]);

        assert_sel_zero_idle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
            !wr_en_o[w] |-> (wr_sel_o[w*SELW +: SELW] == '0));
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_r
        assert_pred_on_tokens_R8: assert property (@(posedge clk_i) disable iff (rst_i)
            (rd_tok_prd_o[r*NUM_DST +: NUM_DST] & ~rd_tok_vld_o[r*NUM_DST +: NUM_DST]) == '0);

        assert_two_dest_max_R11: assert property (@(posedge clk_i) disable iff (rst_i)
            $countones(rd_tok_vld_o[r*NUM_DST +: NUM_DST]) <= 2);
    end

endmodule

bind rf_token_shadow rf_token_shadow_chk #(
    .NUM_WR  (NUM_WR),
    .NUM_SRC (NUM_SRC),
    .NUM_RD  (NUM_RD),
    .NUM_DST (NUM_DST)
) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .wr_tok_vld_i (wr_tok_vld_i),
    .wr_tok_prd_i (wr_tok_prd_i),
    .wr_en_o      (wr_en_o),
    .wr_sel_o     (wr_sel_o),
    .wr_err_o     (wr_err_o),
    .rd_tok_vld_o (rd_tok_vld_o),
    .rd_tok_prd_o (rd_tok_prd_o)
);

// File: tb/rf_token_shadow_tb_top.sv
`timescale 1ns/1ps
module rf_token_shadow_tb_top;

    localparam int NWR = 2, NSRC = 4, NRD = 2, NDST = 4, DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic [NWR*NSRC-1:0] tv, tp;
    logic [NWR-1:0]   en, err;
    logic [NWR*2-1:0] sel;
    logic             cwe;
    logic [0:0]       cport;
    logic [2:0]       caddr, slot;
    logic             cgen;
    logic [3:0]       cd0, cd1;
    logic [NRD-1:0]   stage;
    logic [NRD*NDST-1:0] ov, op;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    rf_token_shadow #(.NUM_WR(NWR), .NUM_SRC(NSRC), .NUM_RD(NRD),
                      .NUM_DST(NDST), .CFG_DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_i(rst), .wr_tok_vld_i(tv), .wr_tok_prd_i(tp),
        .wr_en_o(en), .wr_sel_o(sel), .wr_err_o(err),
        .cfg_we_i(cwe), .cfg_port_i(cport), .cfg_addr_i(caddr), .cfg_gen_i(cgen),
        .cfg_dst0_i(cd0), .cfg_dst1_i(cd1), .slot_i(slot), .stage_i(stage),
        .rd_tok_vld_o(ov), .rd_tok_prd_o(op)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] rx_model(input logic [3:0] v, input logic [3:0] p);
        // returns {err, en, sel[1:0]}
        int n = $countones(v);
        logic [1:0] idx = 2'd0;
        for (int i = 3; i >= 0; i--) if (v[i]) idx = 2'(i);
        if (n > 1) return 4'b1000;
        if (n == 1 && p[idx]) return {2'b01, idx};
        return 4'b0000;
    endfunction

    function automatic logic [3:0] slot_ok(input logic [3:0] d);
        return ($countones(d) == 1) ? d : 4'd0;
    endfunction

    function automatic string rx_tag(input logic [3:0] v, input logic [3:0] p);
        int n = $countones(v);
        if (n == 0) return (p != 0) ? "R4 R6" : "R4";
        if (n > 1) return "R5";
        return ((v & p) != 0) ? "R2 R6" : "R3 R6";
    endfunction

    initial begin
        rst = 1'b1; tv = '0; tp = '0; cwe = 1'b0; cport = '0; caddr = '0;
        cgen = 1'b0; cd0 = '0; cd1 = '0; slot = '0; stage = '0;
        @(negedge clk);
        tv = '1; tp = '1; stage = '1;
        repeat (3) step();
        check(en == 0 && err == 0 && sel == 0 && ov == 0 && op == 0, "R1 in reset",
              {en, err, sel, ov, op}, 0);
        rst = 1'b0; tv = '0; tp = '0;
        step();
        check(en == 0 && err == 0 && sel == 0 && ov == 0 && op == 0, "R1 after reset",
              {en, err, sel, ov, op}, 0);

        // Cleared memories: no tokens from any slot
        for (int a = 0; a < DEPTH; a++) begin
            slot = 3'(a); stage = '1;
            step();
            check(ov == 0 && op == 0, "R1 cleared entry", {ov, op}, 0);
        end

        // Receiver sweep: every valid x predicate pattern on port 0
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic [3:0] v0 = 4'(a), p0 = 4'(b);
                logic [3:0] v1 = ~v0, p1 = {p0[0], p0[3:1]};
                logic [3:0] e0, e1;
                tv = {v1, v0}; tp = {p1, p0};
                step();
                e0 = rx_model(v0, p0);
                e1 = rx_model(v1, p1);
                check({err[0], en[0], sel[1:0]} == e0, $sformatf("%s port0", rx_tag(v0, p0)),
                      {err[0], en[0], sel[1:0]}, e0);
                check({err[1], en[1], sel[3:2]} == e1, $sformatf("%s port1", rx_tag(v1, p1)),
                      {err[1], en[1], sel[3:2]}, e1);
            end
        end
        tv = '0; tp = '0;

        // Sender sweep: generation bit x both destination slots
        for (int k = 0; k < 512; k++) begin
            logic       g   = k[8];
            logic [3:0] d0  = 4'(k >> 4);
            logic [3:0] d1  = 4'(k);
            logic [2:0] ad  = 3'(k);
            logic       g1  = ~g;
            logic [3:0] d10 = d1, d11 = ~d0;
            logic [1:0] stg = 2'(k >> 1) ^ 2'(k);
            logic [3:0] ev0, ev1, ep0, ep1;
            string      t0;
            cwe = 1'b1; cport = 1'b0; caddr = ad; cgen = g; cd0 = d0; cd1 = d1;
            step();
            cport = 1'b1; cgen = g1; cd0 = d10; cd1 = d11;
            step();
            cwe = 1'b0; slot = ad; stage = stg;
            step();
            ev0 = g  ? (slot_ok(d0)  | slot_ok(d1))  : 4'd0;
            ev1 = g1 ? (slot_ok(d10) | slot_ok(d11)) : 4'd0;
            ep0 = stg[0] ? ev0 : 4'd0;
            ep1 = stg[1] ? ev1 : 4'd0;
            if (!g) t0 = "R7 R9";
            else if (slot_ok(d0) == 0 || slot_ok(d1) == 0) t0 = "R7 R10";
            else if (d0 == d1) t0 = "R7 R11";
            else t0 = "R7 R8";
            check(ov[3:0] == ev0 && op[3:0] == ep0, $sformatf("%s port0", t0),
                  {ov[3:0], op[3:0]}, {ev0, ep0});
            check(ov[7:4] == ev1 && op[7:4] == ep1, "R7 R8 port1",
                  {ov[7:4], op[7:4]}, {ev1, ep1});
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule